// File: doc/BRIEF.md
# Scan-Accessed Debug Mailbox

This block gives an external debugger a path to trade 32-bit words with an on-chip processor through a boundary-scan data register. A TAP controller outside the block supplies capture, shift and update strobes on TCK. Each scan carries one command: a data word, a register address and a direction flag. The command acts only when the update strobe arrives. Two addresses are live. One is a read-only status word that shows two handshake flags. The other is the mailbox data register. Writing to it sends a word to the processor. Reading it collects the word the processor has posted.

On the system clock side, incoming words leave on a valid/ready stream (`rx_*`). `rx_valid` stays high, and `rx_data` stays stable, until the processor accepts with `rx_ready`. Outgoing words enter on a second valid/ready stream (`tx_*`). While an earlier outgoing word is still waiting for the debugger, `tx_ready` stays low. A `tx_valid` asserted during that time is not accepted, and the posted word is kept. Back-pressure from the debugger side reaches the processor only through `tx_ready`. The two flags cross clock domains as toggles through synchronizer chains. Data words never pass through a synchronizer. They are held stable until the other side has acknowledged them.

A read takes two scans. The first scan carries the address and passes through update. The capture phase of the next scan loads the selected register, and that scan shifts it out.

Top module: `dbg_mailbox`

## Requirements
- R1: The scan register is 38 bits wide. Bits 31:0 hold the data, bits 36:32 hold the address and bit 37 is the direction (1 = write, 0 = read). TDO carries bit 0 first, and TDI enters at bit 37.
- R2: A command acts only on the update strobe. A scan that shifts a write but never reaches update leaves every flag and register unchanged.
- R3: A read command (bit 37 = 0) that passes update arms a read. The next capture loads the selected 32-bit value into bits 31:0 and zero into bits 37:32. A capture with no armed read loads all zeros.
- R4: Address 0x04 reads as the status word: bit 0 is the incoming-pending flag, bit 1 is the outgoing-ready flag, and bits 31:2 are zero.
- R5: A debugger write to address 0x05 sets the incoming-pending flag. `rx_valid` follows that flag, with the word on `rx_data`. An `rx_valid && rx_ready` cycle clears the flag.
- R6: A debugger write to 0x05 while the incoming-pending flag is 1 is dropped, and the earlier word stays in place.
- R7: A `tx_valid && tx_ready` cycle stores `tx_data` and sets the outgoing-ready flag (`stat_w`). While the flag is 1, `tx_ready` is 0, and any offered word is refused without overwriting the posted one.
- R8: A debugger read of 0x05 returns the most recently posted word. When the outgoing-ready flag was set, the capture that delivers the word clears the flag, and `tx_ready` returns to 1.
- R9: Writes to 0x04 or to any unused address have no effect. Reads of unused addresses return zero.
- R10: After reset both flags are 0, `rx_valid` is 0, `tx_ready` is 1, TDO is 0 and the status word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Scan clock |
| trst_n | input | 1 | Scan-side reset, active low |
| tdi | input | 1 | Serial scan input |
| capture_dr | input | 1 | Capture strobe from the TAP |
| shift_dr | input | 1 | Shift strobe from the TAP |
| update_dr | input | 1 | Update strobe from the TAP |
| tdo | output | 1 | Serial scan output, bit 0 of the scan register |
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low |
| rx_valid | output | 1 | Incoming word available |
| rx_ready | input | 1 | Processor takes the incoming word |
| rx_data | output | 32 | Incoming word |
| tx_valid | input | 1 | Processor offers an outgoing word |
| tx_ready | output | 1 | Outgoing slot free |
| tx_data | input | 32 | Outgoing word |
| stat_r | output | 1 | Incoming-pending flag, system side |
| stat_w | output | 1 | Outgoing-ready flag, system side |

## Verification
The hardest cases to reach from the ports are the refusals. One is a second debugger write that lands while the first word is still uncollected. The other is a processor post offered while the earlier word still sits unread. In both, the flag has to be seen in the other clock domain before the second attempt. The stimulus sends two complete write scans back to back before the processor takes anything, then checks that the collected word is the first one. It also posts a word, waits for the flag to cross, offers a second word against a low `tx_ready`, and reads the mailbox through two scans to confirm that the first word survived.

// File: rtl/dbgmb_pkg.sv
package dbgmb_pkg;
  localparam int unsigned MB_DATA_W    = 32;
  localparam int unsigned MB_ADDR_W    = 5;
  localparam int unsigned MB_SYNC      = 2;
  localparam int unsigned MB_STAT_ADDR = 4;
  localparam int unsigned MB_MBOX_ADDR = 5;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_MBOX = 2'd2
  } sel_e;
endpackage

// File: rtl/dbgmb_sync.sv
module dbgmb_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= '0;
      else if (g == 0) chain[g] <= d;
      else chain[g] <= chain[(g == 0) ? 0 : g - 1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dbgmb_scan.sv
module dbgmb_scan #(
  parameter int unsigned SCAN_W = 38
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              capture,
  input  logic              shift,
  input  logic              tdi,
  input  logic [SCAN_W-1:0] load_val,
  output logic [SCAN_W-1:0] sr_q,
  output logic              tdo
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) sr_q <= '0;
    else if (capture) sr_q <= load_val;
    else if (shift) sr_q <= {tdi, sr_q[SCAN_W-1:1]};
  end

  assign tdo = sr_q[0];
endmodule

// File: rtl/dbgmb_tck_side.sv
module dbgmb_tck_side
  import dbgmb_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned SCAN_W = DATA_W + ADDR_W + 1
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              capture,
  input  logic              update,
  input  logic [SCAN_W-1:0] scan_q,
  input  logic              in_ack_s,
  input  logic              out_tog_s,
  input  logic [DATA_W-1:0] out_word,
  output logic [DATA_W-1:0] in_word,
  output logic              in_tog,
  output logic              out_ack_tog,
  output logic [DATA_W-1:0] cap_word
);
  logic              rd_pend;
  sel_e              rd_sel;
  sel_e              upd_sel;
  logic              r_flag;
  logic              w_flag;
  logic              cmd_wr;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data;

  assign cmd_wr   = scan_q[SCAN_W-1];
  assign cmd_addr = scan_q[DATA_W +: ADDR_W];
  assign cmd_data = scan_q[DATA_W-1:0];

  assign r_flag = in_tog ^ in_ack_s;
  assign w_flag = out_tog_s ^ out_ack_tog;

  always_comb begin
    if (cmd_addr == ADDR_W'(MB_STAT_ADDR))      upd_sel = SEL_STAT;
    else if (cmd_addr == ADDR_W'(MB_MBOX_ADDR)) upd_sel = SEL_MBOX;
    else                                        upd_sel = SEL_NONE;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      in_word     <= '0;
      in_tog      <= 1'b0;
      out_ack_tog <= 1'b0;
      rd_pend     <= 1'b0;
      rd_sel      <= SEL_NONE;
    end else if (capture) begin
      rd_pend <= 1'b0;
      if (rd_pend && rd_sel == SEL_MBOX && w_flag) out_ack_tog <= ~out_ack_tog;
    end else if (update) begin
      if (cmd_wr) begin
        rd_pend <= 1'b0;
        if (upd_sel == SEL_MBOX && !r_flag) begin
          in_word <= cmd_data;
          in_tog  <= ~in_tog;
        end
      end else begin
        rd_pend <= 1'b1;
        rd_sel  <= upd_sel;
      end
    end
  end

  always_comb begin
    cap_word = '0;
    if (rd_pend) begin
      case (rd_sel)
        SEL_STAT: cap_word = DATA_W'({w_flag, r_flag});
        SEL_MBOX: cap_word = out_word;
        default:  cap_word = '0;
      endcase
    end
  end
endmodule

// File: rtl/dbgmb_sys_side.sv
module dbgmb_sys_side #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_tog_s,
  input  logic [DATA_W-1:0] in_word,
  input  logic              out_ack_s,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              stat_r,
  output logic              stat_w,
  output logic [DATA_W-1:0] out_word,
  output logic              in_ack_tog,
  output logic              out_tog
);
  logic r_flag;
  logic w_flag;

  assign r_flag   = in_tog_s ^ in_ack_tog;
  assign w_flag   = out_tog ^ out_ack_s;
  assign rx_valid = r_flag;
  assign rx_data  = in_word;
  assign tx_ready = ~w_flag;
  assign stat_r   = r_flag;
  assign stat_w   = w_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_ack_tog <= 1'b0;
      out_tog    <= 1'b0;
      out_word   <= '0;
    end else begin
      if (rx_valid && rx_ready) in_ack_tog <= ~in_ack_tog;
      if (tx_valid && tx_ready) begin
        out_word <= tx_data;
        out_tog  <= ~out_tog;
      end
    end
  end
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
  import dbgmb_pkg::*;
#(
  parameter int unsigned DATA_W = MB_DATA_W,
  parameter int unsigned ADDR_W = MB_ADDR_W,
  parameter int unsigned SYNC_N = MB_SYNC,
  localparam int unsigned SCAN_W = DATA_W + ADDR_W + 1
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tdi,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  output logic              tdo,
  input  logic              clk,
  input  logic              rst_n,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              stat_r,
  output logic              stat_w
);
  logic [SCAN_W-1:0] scan_q;
  logic [DATA_W-1:0] cap_word;
  logic [DATA_W-1:0] in_word;
  logic [DATA_W-1:0] out_word;
  logic              in_tog, in_tog_s;
  logic              in_ack_tog, in_ack_s;
  logic              out_tog, out_tog_s;
  logic              out_ack_tog, out_ack_s;

  dbgmb_scan #(.SCAN_W(SCAN_W)) scan_i (
    .tck(tck), .trst_n(trst_n), .capture(capture_dr), .shift(shift_dr),
    .tdi(tdi), .load_val(SCAN_W'(cap_word)), .sr_q(scan_q), .tdo(tdo)
  );

  dbgmb_tck_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) tck_i (
    .tck(tck), .trst_n(trst_n), .capture(capture_dr), .update(update_dr),
    .scan_q(scan_q), .in_ack_s(in_ack_s), .out_tog_s(out_tog_s),
    .out_word(out_word), .in_word(in_word), .in_tog(in_tog),
    .out_ack_tog(out_ack_tog), .cap_word(cap_word)
  );

  dbgmb_sync #(.STAGES(SYNC_N), .WIDTH(2)) to_tck_i (
    .clk(tck), .rst_n(trst_n),
    .d({in_ack_tog, out_tog}), .q({in_ack_s, out_tog_s})
  );

  dbgmb_sync #(.STAGES(SYNC_N), .WIDTH(2)) to_sys_i (
    .clk(clk), .rst_n(rst_n),
    .d({in_tog, out_ack_tog}), .q({in_tog_s, out_ack_s})
  );

  dbgmb_sys_side #(.DATA_W(DATA_W)) sys_i (
    .clk(clk), .rst_n(rst_n), .in_tog_s(in_tog_s), .in_word(in_word),
    .out_ack_s(out_ack_s), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .stat_r(stat_r), .stat_w(stat_w),
    .out_word(out_word), .in_ack_tog(in_ack_tog), .out_tog(out_tog)
  );
endmodule

// File: rtl/dbgmb_checker.sv
module dbgmb_checker #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tck,
  input logic              trst_n,
  input logic              capture_dr,
  input logic              shift_dr,
  input logic              update_dr,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              stat_w,
  input logic [DATA_W-1:0] out_word
);
  AST_STROBE_EXCL: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({capture_dr, shift_dr, update_dr})); // R1

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !trst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data)); // R5

  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n || !trst_n)
    rx_valid && rx_ready |=> !rx_valid); // R5

  AST_TX_SET: assert property (@(posedge clk) disable iff (!rst_n || !trst_n)
    tx_valid && tx_ready |=> !tx_ready && stat_w); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !trst_n)
    !tx_ready |=> $stable(out_word)); // R7
endmodule

bind dbg_mailbox dbgmb_checker #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tck(tck), .trst_n(trst_n),
  .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .stat_w(stat_w),
  .out_word(out_word)
);

// File: tb/dbg_mailbox_tb_top.sv
module dbg_mailbox_tb_top;
  logic tck = 1'b0, trst_n = 1'b0, tdi = 1'b0;
  logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
  logic tdo;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid, rx_ready = 1'b0;
  logic [31:0] rx_data;
  logic tx_valid = 1'b0, tx_ready;
  logic [31:0] tx_data = '0;
  logic stat_r, stat_w;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always #17 tck = ~tck;

  dbg_mailbox dut_i (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdo(tdo),
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .stat_r(stat_r), .stat_w(stat_w)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_RX = 2'd2, OP_TX = 2'd3;
  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{OP_RD, 5'h04, 32'h0,         32'h0},          // R10 status after reset
    '{OP_WR, 5'h05, 32'hA5A5_0001, 32'h0},          // R5 debugger sends
    '{OP_RD, 5'h04, 32'h0,         32'h1},          // R4 R5 pending bit 0
    '{OP_RX, 5'h00, 32'h0,         32'hA5A5_0001},  // R5 processor takes
    '{OP_RD, 5'h04, 32'h0,         32'h0},          // R5 cleared
    '{OP_TX, 5'h00, 32'h1234_5678, 32'h0},          // R7 processor posts
    '{OP_RD, 5'h04, 32'h0,         32'h2},          // R4 ready bit 1
    '{OP_RD, 5'h05, 32'h0,         32'h1234_5678},  // R8 collect
    '{OP_RD, 5'h04, 32'h0,         32'h0},          // R8 flag cleared
    '{OP_WR, 5'h04, 32'hFFFF_FFFF, 32'h0},          // R9 write to status
    '{OP_RD, 5'h04, 32'h0,         32'h0},          // R9 unchanged
    '{OP_WR, 5'h09, 32'hDEAD_BEEF, 32'h0},          // R9 unused write
    '{OP_RD, 5'h09, 32'h0,         32'h0},          // R9 unused read
    '{OP_RD, 5'h05, 32'h0,         32'h1234_5678}   // R8 held word
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge tck);
  endtask

  task automatic scan(input logic [37:0] din, input bit do_upd, output logic [37:0] dout);
    @(negedge tck); capture_dr = 1'b1;
    @(negedge tck); capture_dr = 1'b0;
    for (int i = 0; i < 38; i++) begin
      dout[i] = tdo;
      tdi = din[i];
      shift_dr = 1'b1;
      @(negedge tck);
    end
    shift_dr = 1'b0;
    if (do_upd) begin
      update_dr = 1'b1;
      @(negedge tck);
      update_dr = 1'b0;
    end
    @(negedge tck);
  endtask

  task automatic dbg_write(input logic [4:0] a, input logic [31:0] d);
    logic [37:0] junk;
    scan({1'b1, a, d}, 1'b1, junk);
  endtask

  task automatic dbg_read(input logic [4:0] a, output logic [37:0] d);
    logic [37:0] junk;
    scan({1'b0, a, 32'h0}, 1'b1, junk);
    scan(38'h0, 1'b1, d);
  endtask

  task automatic sys_take(input string req, input logic [31:0] exp);
    int n = 0;
    @(negedge clk);
    while (!rx_valid && n < 50) begin @(negedge clk); n++; end
    check(req, {32'h0, rx_data}, {32'h0, exp});
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic sys_post(input string req, input logic [31:0] d);
    @(negedge clk);
    check(req, {63'h0, tx_ready}, 64'h1);
    tx_valid = 1'b1;
    tx_data = d;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R10 act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [37:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    trst_n = 1'b1;
    repeat (4) @(negedge tck);

    // R10 reset state at the ports
    @(negedge clk);
    check("R10 tdo", {63'h0, tdo}, 64'h0);
    check("R10 rx_valid", {63'h0, rx_valid}, 64'h0);
    check("R10 tx_ready", {63'h0, tx_ready}, 64'h1);
    check("R10 flags", {62'h0, stat_w, stat_r}, 64'h0);

    for (int v = 0; v < NV; v++) begin
      case (VECS[v].op)
        OP_WR: dbg_write(VECS[v].addr, VECS[v].data);
        OP_RD: begin
          dbg_read(VECS[v].addr, d);
          check($sformatf("R3 R4 R8 R9 vec%0d", v), {26'h0, d}, {32'h0, VECS[v].exp});
        end
        OP_RX: sys_take($sformatf("R5 vec%0d", v), VECS[v].exp);
        default: sys_post($sformatf("R7 vec%0d", v), VECS[v].data);
      endcase
      settle();
    end

    // R2: write shifted but no update
    scan({1'b1, 5'h05, 32'h7777_7777}, 1'b0, d);
    settle();
    check("R2 no update rx_valid", {63'h0, rx_valid}, 64'h0);
    check("R2 no update stat_r", {63'h0, stat_r}, 64'h0);

    // R3: capture without an armed read gives zero
    dbg_write(5'h0A, 32'h0);
    scan(38'h0, 1'b0, d);
    check("R3 unarmed capture", {26'h0, d}, 64'h0);

    // R6: second write while pending is dropped
    dbg_write(5'h05, 32'h1111_1111);
    settle();
    dbg_write(5'h05, 32'h2222_2222);
    settle();
    // R1: full 38-bit status image, upper bits zero
    dbg_read(5'h04, d);
    check("R1 R4 status image", {26'h0, d}, 64'h1);
    sys_take("R6 first word kept", 32'h1111_1111);
    settle();
    check("R6 nothing more", {63'h0, rx_valid}, 64'h0);

    // R7: refused post while outgoing word waits
    sys_post("R7 accept", 32'hCAFE_0001);
    settle();
    @(negedge clk);
    check("R7 busy tx_ready", {63'h0, tx_ready}, 64'h0);
    check("R7 stat_w", {63'h0, stat_w}, 64'h1);
    tx_valid = 1'b1;
    tx_data = 32'hBAD0_BAD0;
    @(negedge clk);
    tx_valid = 1'b0;
    dbg_read(5'h05, d);
    check("R7 R8 posted word kept", {26'h0, d}, {32'h0, 32'hCAFE_0001});
    settle();
    @(negedge clk);
    check("R8 tx_ready back", {63'h0, tx_ready}, 64'h1);
    check("R8 stat_w cleared", {63'h0, stat_w}, 64'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule